// File: doc/BRIEF.md
# Non-display area interval scan controller

This block sequences the drive of the panel region that lies outside the partial-display windows. On every frame-start strobe it decides whether the gate lines are scanned in that frame, flips the liquid-crystal drive polarity when a scan happens, and selects the level that the source outputs present: the two extreme gray rails, ground or high impedance. The same strobe also latches the power-save choice. That choice turns off the intermediate grayscale amplifiers and halves the rate of the step-up pump enable.

Software loads a 9-bit control word through a single-cycle write port. The word holds a scan mode, a 4-bit scan-cycle code and a 3-bit source-level code. In interval mode the gate is scanned once every 2k−1 frames for code k. Code 0 scans every frame. A write restarts the interval count, so the next frame scans. A write that lands in the middle of a frame changes nothing at the outputs until the next strobe. Prohibited codes fall back to safe behaviour and set a sticky error flag. The base pump tick comes from an external clock divider, and this block only thins it out.

Top module: `nds_scan_ctrl`

## Requirements
- R1: After reset: `gate_scan`=0, `drive_pol`=0, `src_sel`=3 (high impedance), `amp_mid_en`=1, `cfg_err`=0. Each base tick gives one `pump_en` pulse. The control word resets to interval mode with cycle code 0.
- R2: Control word layout: bits [3:0] hold the cycle code, bits [5:4] the mode, bits [8:6] the level. In mode 2'b10 with cycle code k≥1, the gate scans on the first frame after a write and then once every 2k−1 frames. With code 0 it scans every frame.
- R3: In mode 2'b00 `gate_scan` is 1 for every frame.
- R4: `drive_pol` inverts at a frame strobe exactly when that frame scans, and holds otherwise.
- R5: `src_sel` follows level bits [7:6]. 00 gives 0 (upper rail) when the new `drive_pol` is 0 and 1 (lower rail) when it is 1. 10 gives 2 (ground). 11 gives 3 (high impedance).
- R6: `amp_mid_en` is the inverse of level bit 8, latched at the frame strobe.
- R7: `pump_en` pulses one cycle after a `pump_tick`, and never without one. While level bit 8 is latched as 1, only every second tick passes, starting with the first tick after the setting is entered.
- R8: Mode 2'b01 or 2'b11 behaves as normal scan. Level bits [7:6]=01 give high impedance. Writing either code sets `cfg_err` one cycle later, and the flag stays set until reset.
- R9: Between frame strobes, `gate_scan`, `drive_pol`, `src_sel` and `amp_mid_en` hold, even across a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word: level[8:6], mode[5:4], cycle[3:0] |
| frame_start | input | 1 | One-cycle frame-start strobe |
| pump_tick | input | 1 | Base step-up pump enable from the divider |
| gate_scan | output | 1 | Gate lines scanned in this frame |
| drive_pol | output | 1 | Drive polarity, 0 = positive |
| src_sel | output | 2 | Source level: 0 upper rail, 1 lower rail, 2 ground, 3 high impedance |
| amp_mid_en | output | 1 | Enable for the intermediate grayscale amplifiers |
| pump_en | output | 1 | Step-up pump enable pulse |
| cfg_err | output | 1 | Sticky prohibited-code flag |

## Verification
A wrong interval counter shows up as `gate_scan` asserted on the wrong frame. The bench compares every frame against the model, so it is caught at most 2k−1 frames after a write. A polarity slip shows at the same strobe as a mismatch in `drive_pol`. Because the rail choice depends on polarity, it also shows in `src_sel`. A stuck pump phase shows up as the wrong pulse count within one 40-tick window. A lost error flag is seen in the cycle after the offending write.

// File: rtl/nds_pkg.sv
package nds_pkg;

    localparam int CYC_W  = 4;
    localparam int MODE_W = 2;
    localparam int LVL_W  = 3;
    localparam int CNT_W  = CYC_W + 1;
    localparam int WORD_W = LVL_W + MODE_W + CYC_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_BAD_A    = 2'b01,
        MODE_INTERVAL = 2'b10,
        MODE_BAD_B    = 2'b11
    } scan_mode_e;

    typedef enum logic [1:0] {
        SRC_RAIL_HI = 2'b00,
        SRC_RAIL_LO = 2'b01,
        SRC_GND     = 2'b10,
        SRC_HIZ     = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        scan_mode_e       mode;
        logic [CYC_W-1:0] cyc;
    } ctrl_word_t;

    localparam ctrl_word_t CTRL_RESET = '{level: '0, mode: MODE_INTERVAL, cyc: '0};

    // frames to wait after a scan before the next one (interval 2k-1, wait 2k-2)
    function automatic logic [CNT_W-1:0] wait_frames(input logic [CYC_W-1:0] code);
        logic [CNT_W-1:0] twice;
        twice = {code, 1'b0};
        return (code == '0) ? '0 : twice - CNT_W'(2);
    endfunction

    function automatic logic word_bad(input ctrl_word_t w);
        return (w.mode == MODE_BAD_A) || (w.mode == MODE_BAD_B) || (w.level[1:0] == 2'b01);
    endfunction

endpackage

// File: rtl/nds_cfg_reg.sv
module nds_cfg_reg
    import nds_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [WORD_W-1:0]   wdata,
    output ctrl_word_t          ctrl,
    output logic                err
);
    ctrl_word_t wword;
    assign wword = ctrl_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
            err  <= 1'b0;
        end else if (we) begin
            ctrl <= wword;
            if (word_bad(wword)) err <= 1'b1;
        end
    end

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);
    a_r8_bad_write_flags: assert property (@(posedge clk) disable iff (rst)
        (we && word_bad(wword)) |=> err);
endmodule

// File: rtl/nds_frame_seq.sv
module nds_frame_seq
    import nds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       reload,
    input  ctrl_word_t ctrl,
    output logic       gate_scan,
    output logic       drive_pol,
    output src_sel_e   src_sel,
    output logic       amp_mid_en,
    output logic       half_rate
);
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             interval, fire, pol_nxt;
    src_sel_e         src_nxt;

    always_comb begin
        interval = (ctrl.mode == MODE_INTERVAL);
        fire     = !interval || (cnt == '0);
        if (!interval)      cnt_nxt = '0;
        else if (cnt == '0) cnt_nxt = wait_frames(ctrl.cyc);
        else                cnt_nxt = cnt - CNT_W'(1);
        pol_nxt = drive_pol ^ fire;
        case (ctrl.level[1:0])
            2'b00:   src_nxt = pol_nxt ? SRC_RAIL_LO : SRC_RAIL_HI;
            2'b10:   src_nxt = SRC_GND;
            default: src_nxt = SRC_HIZ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            gate_scan  <= 1'b0;
            drive_pol  <= 1'b0;
            src_sel    <= SRC_HIZ;
            amp_mid_en <= 1'b1;
            half_rate  <= 1'b0;
        end else begin
            if (frame_start) begin
                cnt        <= cnt_nxt;
                gate_scan  <= fire;
                drive_pol  <= pol_nxt;
                src_sel    <= src_nxt;
                amp_mid_en <= ~ctrl.level[LVL_W-1];
                half_rate  <= ctrl.level[LVL_W-1];
            end
            if (reload) cnt <= '0;
        end
    end

    a_r3_normal_scans: assert property (@(posedge clk) disable iff (rst)
        (frame_start && ctrl.mode != MODE_INTERVAL) |=> gate_scan);
    a_r4_pol_tracks_scan: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> ((drive_pol != $past(drive_pol)) == gate_scan));
    a_r9_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(gate_scan) && $stable(drive_pol) && $stable(src_sel)
                          && $stable(amp_mid_en)));
    a_r5_rail_hi_positive: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_RAIL_HI) |-> !drive_pol);
    a_r5_rail_lo_negative: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_RAIL_LO) |-> drive_pol);
    a_r6_amp_vs_half: assert property (@(posedge clk) disable iff (rst)
        amp_mid_en != half_rate);
endmodule

// File: rtl/nds_pump_div.sv
module nds_pump_div (
    input  logic clk,
    input  logic rst,
    input  logic half_rate,
    input  logic tick,
    output logic pump_en
);
    logic pass_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_next <= 1'b1;
            pump_en   <= 1'b0;
        end else begin
            pump_en <= tick && (!half_rate || pass_next);
            if (!half_rate)  pass_next <= 1'b1;
            else if (tick)   pass_next <= ~pass_next;
        end
    end

    a_r7_no_tick_no_pump: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !pump_en);
    a_r7_full_rate_passes: assert property (@(posedge clk) disable iff (rst)
        (tick && !half_rate) |=> pump_en);
endmodule

// File: rtl/nds_scan_ctrl.sv
module nds_scan_ctrl
    import nds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              pump_tick,
    output logic              gate_scan,
    output logic              drive_pol,
    output logic [1:0]        src_sel,
    output logic              amp_mid_en,
    output logic              pump_en,
    output logic              cfg_err
);
    ctrl_word_t ctrl;
    src_sel_e   src_e;
    logic       half_rate;

    nds_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .err   (cfg_err)
    );

    nds_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .reload      (cfg_we),
        .ctrl        (ctrl),
        .gate_scan   (gate_scan),
        .drive_pol   (drive_pol),
        .src_sel     (src_e),
        .amp_mid_en  (amp_mid_en),
        .half_rate   (half_rate)
    );

    nds_pump_div u_pump (
        .clk       (clk),
        .rst       (rst),
        .half_rate (half_rate),
        .tick      (pump_tick),
        .pump_en   (pump_en)
    );

    assign src_sel = src_e;
endmodule

// File: tb/nds_scan_ctrl_bench.sv
module nds_scan_ctrl_bench;
    logic       clk = 0, rst = 1, cfg_we = 0, frame_start = 0, pump_tick = 0;
    logic [8:0] cfg_wdata = '0;
    logic       gate_scan, drive_pol, amp_mid_en, pump_en, cfg_err;
    logic [1:0] src_sel;

    int checks = 0, errors = 0;
    logic done = 0;

    // model state
    logic [8:0] m_cfg;
    int         m_cnt;
    logic       m_gate, m_pol, m_amp, m_half, m_err;
    logic [1:0] m_src;

    always #2 clk = ~clk;

    nds_scan_ctrl u_nds_scan_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .pump_tick(pump_tick), .gate_scan(gate_scan),
        .drive_pol(drive_pol), .src_sel(src_sel), .amp_mid_en(amp_mid_en),
        .pump_en(pump_en), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wait_of(input int code);
        return (code == 0) ? 0 : 2 * code - 2;
    endfunction

    function automatic bit is_bad(input logic [8:0] w);
        return (w[5:4] == 2'b01) || (w[5:4] == 2'b11) || (w[7:6] == 2'b01);
    endfunction

    task automatic check_outs(input string req);
        check(gate_scan == m_gate, {req, " gate_scan"}, gate_scan, m_gate);
        check(drive_pol == m_pol, {req, " drive_pol"}, drive_pol, m_pol);
        check(src_sel == m_src, {req, " src_sel"}, src_sel, m_src);
        check(amp_mid_en == m_amp, {req, " amp_mid_en"}, amp_mid_en, m_amp);
        check(cfg_err == m_err, {req, " cfg_err"}, cfg_err, m_err);
    endtask

    task automatic write_cfg(input logic [8:0] w);
        @(negedge clk); cfg_we = 1; cfg_wdata = w;
        @(negedge clk); cfg_we = 0;
        m_cfg = w; m_cnt = 0;
        if (is_bad(w)) m_err = 1;
        check_outs("R9/R8 after write");
    endtask

    task automatic do_frame(input string req);
        bit fire;
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        if (m_cfg[5:4] == 2'b10) begin
            fire  = (m_cnt == 0);
            m_cnt = fire ? wait_of(int'(m_cfg[3:0])) : m_cnt - 1;
        end else begin
            fire  = 1; m_cnt = 0;
        end
        m_gate = fire;
        m_pol  = m_pol ^ fire;
        case (m_cfg[7:6])
            2'b00:   m_src = m_pol ? 2'd1 : 2'd0;
            2'b10:   m_src = 2'd2;
            default: m_src = 2'd3;
        endcase
        m_amp  = ~m_cfg[8];
        m_half = m_cfg[8];
        check_outs(req);
        @(negedge clk);
        check_outs("R9 hold");
    endtask

    task automatic pump_window(input int ticks, input string req);
        int pulses = 0;
        for (int i = 0; i < 2 * ticks; i++) begin
            @(negedge clk);
            if (pump_en) pulses++;
            pump_tick = (i % 2 == 0);
        end
        @(negedge clk); if (pump_en) pulses++; pump_tick = 0;
        @(negedge clk); if (pump_en) pulses++;
        check(pulses == (m_half ? ticks / 2 : ticks), req, pulses, m_half ? ticks / 2 : ticks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int scans;
        void'($urandom(32'h5EED_1234));
        m_cfg = 9'h020; m_cnt = 0; m_gate = 0; m_pol = 0; m_src = 2'd3;
        m_amp = 1; m_half = 0; m_err = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_outs("R1 reset");
        check(pump_en == 0, "R1 pump idle", pump_en, 0);
        pump_window(10, "R1 full-rate pump");
        do_frame("R2 default code 0");
        do_frame("R2 default code 0");

        // R3 normal scan, rails alternate (R5)
        write_cfg({3'b000, 2'b00, 4'd7});
        for (int i = 0; i < 5; i++) do_frame("R3 normal scan / R5 rails");

        // R2 interval of 5 frames, ground level
        write_cfg({3'b010, 2'b10, 4'd3});
        scans = 0;
        for (int i = 0; i < 10; i++) begin
            do_frame("R2 interval 5 / R4");
            scans += gate_scan;
        end
        check(scans == 2, "R2 scans in 10 frames at code 3", scans, 2);

        // R2 longest interval, power save (R6, R7)
        write_cfg({3'b100, 2'b10, 4'd15});
        for (int i = 0; i < 31; i++) do_frame("R2 interval 29 / R6");
        pump_window(40, "R7 half-rate pump");

        // R9 mid-frame write leaves outputs until the next strobe
        write_cfg({3'b011, 2'b00, 4'd0});
        do_frame("R9 write applies at strobe");
        pump_window(40, "R7 back to full rate");

        // R8 prohibited level then mode
        check(cfg_err == 0, "R8 flag clear before bad write", cfg_err, 0);
        write_cfg({3'b001, 2'b10, 4'd2});
        do_frame("R8 bad level gives HiZ");
        write_cfg({3'b000, 2'b11, 4'd2});
        for (int i = 0; i < 3; i++) do_frame("R8 bad mode scans every frame");

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [8:0] w;
            w = 9'($urandom);
            if ($urandom % 4 != 0) w[5:4] = 2'b10;
            write_cfg(w);
            for (int f = 0; f < 1 + int'($urandom % 32); f++) do_frame("R2/R4/R5 random");
            if (n % 10 == 0) pump_window(20, "R7 random pump");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule